// File: doc/BRIEF.md
# Nested Zero-Overhead Loop Controller

This block provides the hardware loop control for a program sequencer. It has two loop mechanisms. A block loop repeats a range of instruction addresses. Block loops nest to a parameterised depth, four by default. A single-instruction repeat re-issues one instruction address. Each block level holds a first address, a last address and an iteration count. The repeat holds an address and its own count.

The block watches every fetch. When the fetch address equals the last address of the innermost active level and that level's count is non-zero, the block drives a next-PC override to the level's first address in the same cycle, with no bubble. When the count is zero, the level is retired instead. For the repeat, the block raises a hold output so that the fetch stage issues the same address again.

An interrupt freezes all loop state. Loop activity resumes unchanged once the return is signalled, and a repeat that was interrupted fetches its instruction again. Decoding of the setup instructions belongs to the surrounding sequencer. That sequencer presents the commands as single-cycle strobes with their operands.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset, no block level and no repeat are active, and `pc_override`, `rep_hold` and `nest_overflow` are all low.
- R2: A fetch (`fetch_valid` high) whose address equals the last address of the innermost level, when that level's count is non-zero, raises `pc_override` in the same cycle with `pc_override_addr` set to the level's first address, and it decrements the count. A loaded count N therefore gives N+1 passes.
- R3: A fetch at the last address when the count is zero raises no override and retires the level. The next outer level governs from the next fetch on, even a fetch at that same address.
- R4: Up to DEPTH block levels can be active at once. A block command while all levels are in use changes no level, and it raises `nest_overflow` for exactly the one cycle that follows the command.
- R5: After a repeat command with count N, each fetch at the repeat address raises `rep_hold` while the count is non-zero and decrements it. The fetch that finds a zero count raises no hold and disarms the repeat, so the instruction issues N+1 times.
- R6: A repeat may sit on the last address of a block loop. While `rep_hold` is high, no block-end action takes place. The final, unheld issue is then handled as a normal block-end fetch.
- R7: From the cycle with `irq_enter` high up to and including the cycle with `irq_return` high, `pc_override` and `rep_hold` stay low and the counts do not change. Afterwards, the loops continue exactly where they stopped.
- R8: Block and repeat commands given while frozen by an interrupt are ignored.
- R9: A count of 0xFFFF (the largest 16-bit value) gives 65,536 passes of a block loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_valid | input | 1 | A fetch takes place this cycle |
| fetch_pc | input | AW | Address being fetched |
| blk_cmd | input | 1 | Open a new innermost block loop |
| blk_first | input | AW | First address of the new block |
| blk_last | input | AW | Last address of the new block |
| rep_cmd | input | 1 | Arm the single-instruction repeat |
| rep_addr | input | AW | Address of the instruction to repeat |
| loop_count | input | CW | Count N (N+1 passes) for either command |
| irq_enter | input | 1 | Interrupt taken; the fetch in this cycle is abandoned |
| irq_return | input | 1 | Last frozen cycle; loops resume on the next cycle |
| pc_override | output | 1 | Next fetch must use `pc_override_addr` |
| pc_override_addr | output | AW | Loop first address to branch to |
| rep_hold | output | 1 | Fetch stage must issue the same address again |
| nest_overflow | output | 1 | One-cycle pulse after a rejected block command |

## Verification
The bench builds the block with AW=16, CW=16 and DEPTH=4, which are the default values. With the full 16-bit count, a one-instruction block loaded with 0xFFFF can be run to its 65,536th pass. The 65,535 overrides and the final fall-through are counted exactly. With a depth of four, a fifth nested command is cheap to reach. After it is rejected, the bench unwinds the inner levels one by one and shows that each outer level still holds its own count. It also shows that an inner and an outer level sharing a last address resolve on consecutive fetches.

// File: rtl/hwloop_pkg.sv
// Shared definitions for the hardware loop controller.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package hwloop_pkg;

    // Sequencing mode: loops either act on fetches or are held by an interrupt.
    typedef enum logic {
        SEQ_RUN  = 1'b0,
        SEQ_HELD = 1'b1
    } seq_mode_t;

    // Default geometry.
    localparam int ADDR_W_DEF  = 16;
    localparam int COUNT_W_DEF = 16;
    localparam int LEVELS_DEF  = 4;

endpackage

// File: rtl/hwloop_stack.sv
// Storage for the nested block loops: a LIFO of (first, last, count) levels.
// Supports push, pop and decrement of the innermost count in one cycle. Push
// and pop may coincide (the innermost slot is replaced). Decrement and push may
// coincide (they touch different slots).
// Assumes: the caller never pushes into a full stack without popping, and
// never asserts pop and dec together.
module hwloop_stack #(
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int DEPTH = 4,
    localparam int NW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          dec,
    input  logic [AW-1:0] new_first,
    input  logic [AW-1:0] new_last,
    input  logic [CW-1:0] new_cnt,
    output logic          top_valid,
    output logic [AW-1:0] top_first,
    output logic [AW-1:0] top_last,
    output logic [CW-1:0] top_cnt,
    output logic          full,
    output logic [NW-1:0] level_count
);

    logic [NW-1:0] depth_q;
    logic [IW-1:0] top_idx;
    logic [IW-1:0] wr_idx;

    logic [AW-1:0] first_w [DEPTH];
    logic [AW-1:0] last_w  [DEPTH];
    logic [CW-1:0] cnt_w   [DEPTH];

    // Innermost slot and the slot written by a push.
    always_comb begin
        top_idx = IW'(depth_q - NW'(1));
        wr_idx  = pop ? top_idx : IW'(depth_q);
    end

    // Level counter tracks the number of active levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= '0;
        end else begin
            depth_q <= depth_q + NW'(push) - NW'(pop);
        end
    end

    // One register set per nesting level.
    for (genvar g = 0; g < DEPTH; g++) begin : g_level
        logic [AW-1:0] first_q;
        logic [AW-1:0] last_q;
        logic [CW-1:0] cnt_q;

        // Load on push into this slot, count down when this slot is innermost.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                first_q <= '0;
                last_q  <= '0;
                cnt_q   <= '0;
            end else if (push && (wr_idx == IW'(g))) begin
                first_q <= new_first;
                last_q  <= new_last;
                cnt_q   <= new_cnt;
            end else if (dec && (top_idx == IW'(g))) begin
                cnt_q   <= cnt_q - CW'(1);
            end
        end

        assign first_w[g] = first_q;
        assign last_w[g]  = last_q;
        assign cnt_w[g]   = cnt_q;
    end

    // Present the innermost level and occupancy flags.
    always_comb begin
        top_valid   = (depth_q != '0);
        full        = (depth_q == NW'(DEPTH));
        top_first   = first_w[top_idx];
        top_last    = last_w[top_idx];
        top_cnt     = cnt_w[top_idx];
        level_count = depth_q;
    end

endmodule

// File: rtl/hwloop_rep.sv
// Single-instruction repeat unit. Holds one address and a down-counter.
// A matching enabled fetch raises hold while the count is non-zero, and it
// disarms the unit on the fetch that finds zero.
// Assumes: enable already folds in fetch validity and the interrupt freeze;
// a load has priority over the update from a match in the same cycle.
module hwloop_rep #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [CW-1:0] load_cnt,
    input  logic          enable,
    input  logic [AW-1:0] fetch_pc,
    output logic          hold,
    output logic          armed
);

    logic          armed_q;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic          hit;

    // Match the fetch against the armed address.
    always_comb begin
        hit   = enable && armed_q && (fetch_pc == addr_q);
        hold  = hit && (cnt_q != '0);
        armed = armed_q;
    end

    // Arm on load, count down on held issues, disarm on the final issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            addr_q  <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            armed_q <= 1'b1;
            addr_q  <= load_addr;
            cnt_q   <= load_cnt;
        end else if (hit) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - CW'(1);
            end else begin
                armed_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/hwloop_ctrl.sv
// Nested zero-overhead loop controller (top). Compares each fetch with the
// innermost block level and the repeat unit. It redirects or holds the
// fetch in the same cycle, retires finished levels, rejects over-deep
// nesting and freezes everything across an interrupt.
// Assumes: interrupts do not nest while frozen; block-end checks use the
// state from before any command given in the same cycle.
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int AW    = ADDR_W_DEF,
    parameter int CW    = COUNT_W_DEF,
    parameter int DEPTH = LEVELS_DEF,
    localparam int NW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_pc,
    input  logic          blk_cmd,
    input  logic [AW-1:0] blk_first,
    input  logic [AW-1:0] blk_last,
    input  logic          rep_cmd,
    input  logic [AW-1:0] rep_addr,
    input  logic [CW-1:0] loop_count,
    input  logic          irq_enter,
    input  logic          irq_return,
    output logic          pc_override,
    output logic [AW-1:0] pc_override_addr,
    output logic          rep_hold,
    output logic          nest_overflow
);

    seq_mode_t     mode_q;
    logic          run;
    logic          rep_armed;
    logic          top_valid;
    logic [AW-1:0] top_first;
    logic [AW-1:0] top_last;
    logic [CW-1:0] top_cnt;
    logic          stk_full;
    logic [NW-1:0] level_count;
    logic          blk_end;
    logic          do_dec;
    logic          do_pop;
    logic          do_push;
    logic          push_req;
    logic          ovf_q;

    // Freeze state: held from interrupt entry through the return cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SEQ_RUN;
        end else if (irq_enter) begin
            mode_q <= SEQ_HELD;
        end else if (irq_return) begin
            mode_q <= SEQ_RUN;
        end
    end

    // Loops act only outside an interrupt and not on the abandoned fetch.
    assign run = (mode_q == SEQ_RUN) && !irq_enter;

    hwloop_rep #(
        .AW(AW),
        .CW(CW)
    ) u_rep (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (run && rep_cmd),
        .load_addr(rep_addr),
        .load_cnt (loop_count),
        .enable   (run && fetch_valid),
        .fetch_pc (fetch_pc),
        .hold     (rep_hold),
        .armed    (rep_armed)
    );

    // Block-end decision: redirect with a count left, retire otherwise.
    always_comb begin
        blk_end  = run && fetch_valid && top_valid && !rep_hold
                   && (fetch_pc == top_last);
        do_dec   = blk_end && (top_cnt != '0);
        do_pop   = blk_end && (top_cnt == '0);
        push_req = run && blk_cmd;
        do_push  = push_req && (!stk_full || do_pop);
    end

    hwloop_stack #(
        .AW   (AW),
        .CW   (CW),
        .DEPTH(DEPTH)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (do_push),
        .pop        (do_pop),
        .dec        (do_dec),
        .new_first  (blk_first),
        .new_last   (blk_last),
        .new_cnt    (loop_count),
        .top_valid  (top_valid),
        .top_first  (top_first),
        .top_last   (top_last),
        .top_cnt    (top_cnt),
        .full       (stk_full),
        .level_count(level_count)
    );

    // Rejected-nesting pulse, one cycle after the offending command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= push_req && stk_full && !do_pop;
        end
    end

    // Drive the sequencer-facing outputs.
    always_comb begin
        pc_override      = do_dec;
        pc_override_addr = top_first;
        nest_overflow    = ovf_q;
    end

endmodule

// File: rtl/hwloop_ctrl_chk.sv
// Property checker for hwloop_ctrl, attached by bind below.
// Assumes: connected to the top's ports and its freeze and occupancy state.
module hwloop_ctrl_chk #(
    parameter int DEPTH = 4,
    localparam int NW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_valid,
    input logic          blk_cmd,
    input logic          irq_enter,
    input logic          mode_held,
    input logic          rep_armed,
    input logic [NW-1:0] level_count,
    input logic          pc_override,
    input logic          rep_hold,
    input logic          nest_overflow
);

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (level_count == '0) && !rep_armed && !nest_overflow);

    // R2
    ovr_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_override |-> fetch_valid);

    // R3
    single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(level_count) + 1) >= int'($past(level_count)));

    // R4
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level_count) <= DEPTH);

    // R4
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nest_overflow |-> $past(blk_cmd) && (int'($past(level_count)) == DEPTH));

    // R6
    hold_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rep_hold |-> !pc_override);

    // R7
    frozen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_held || irq_enter) |-> !pc_override && !rep_hold);

    // R8
    frozen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_held |=> $stable(level_count));

endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(
    .DEPTH(DEPTH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_valid  (fetch_valid),
    .blk_cmd      (blk_cmd),
    .irq_enter    (irq_enter),
    .mode_held    (mode_q == hwloop_pkg::SEQ_HELD),
    .rep_armed    (rep_armed),
    .level_count  (level_count),
    .pc_override  (pc_override),
    .rep_hold     (rep_hold),
    .nest_overflow(nest_overflow)
);

// File: tb/hwloop_ctrl_test.sv
// Directed bench for hwloop_ctrl: one task per scenario.
module hwloop_ctrl_test;

    localparam int AW = 16;
    localparam int CW = 16;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic          blk_cmd = 1'b0;
    logic [AW-1:0] blk_first = '0;
    logic [AW-1:0] blk_last = '0;
    logic          rep_cmd = 1'b0;
    logic [AW-1:0] rep_addr = '0;
    logic [CW-1:0] loop_count = '0;
    logic          irq_enter = 1'b0;
    logic          irq_return = 1'b0;
    logic          pc_override;
    logic [AW-1:0] pc_override_addr;
    logic          rep_hold;
    logic          nest_overflow;

    int n_checks = 0;
    int n_fail = 0;

    hwloop_ctrl #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .fetch_valid     (fetch_valid),
        .fetch_pc        (fetch_pc),
        .blk_cmd         (blk_cmd),
        .blk_first       (blk_first),
        .blk_last        (blk_last),
        .rep_cmd         (rep_cmd),
        .rep_addr        (rep_addr),
        .loop_count      (loop_count),
        .irq_enter       (irq_enter),
        .irq_return      (irq_return),
        .pc_override     (pc_override),
        .pc_override_addr(pc_override_addr),
        .rep_hold        (rep_hold),
        .nest_overflow   (nest_overflow)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One fetch; checks override, its target and hold before the edge.
    task automatic fetch_chk(input logic [AW-1:0] pc, input bit e_ovr,
                             input logic [AW-1:0] e_addr, input bit e_hold, input string req);
        fetch_valid = 1'b1;
        fetch_pc    = pc;
        #1;
        check(pc_override == e_ovr, {req, " override"}, pc_override, e_ovr);
        if (e_ovr) check(pc_override_addr == e_addr, {req, " target"}, pc_override_addr, e_addr);
        check(rep_hold == e_hold, {req, " hold"}, rep_hold, e_hold);
        next_cycle();
        fetch_valid = 1'b0;
    endtask

    task automatic push_blk(input logic [AW-1:0] f, input logic [AW-1:0] l, input logic [CW-1:0] n);
        blk_cmd = 1'b1; blk_first = f; blk_last = l; loop_count = n;
        next_cycle();
        blk_cmd = 1'b0;
    endtask

    task automatic arm_rep(input logic [AW-1:0] a, input logic [CW-1:0] n);
        rep_cmd = 1'b1; rep_addr = a; loop_count = n;
        next_cycle();
        rep_cmd = 1'b0;
    endtask

    // R1: outputs idle after reset, even for a fetch at address zero.
    task automatic t_reset();
        #1;
        check(!pc_override && !rep_hold && !nest_overflow, "R1 idle outputs",
              {pc_override, rep_hold, nest_overflow}, 0);
        fetch_chk(16'h0000, 1'b0, '0, 1'b0, "R1 empty fetch");
    endtask

    // R2/R3: count 2 gives three passes, then the level is gone.
    task automatic t_single_block();
        push_blk(16'h0010, 16'h0012, 16'd2);
        for (int p = 0; p < 3; p++) begin
            fetch_chk(16'h0010, 1'b0, '0, 1'b0, "R2 body");
            fetch_chk(16'h0011, 1'b0, '0, 1'b0, "R2 body");
            fetch_chk(16'h0012, p < 2, 16'h0010, 1'b0, p < 2 ? "R2 loop back" : "R3 exit");
        end
        fetch_chk(16'h0012, 1'b0, '0, 1'b0, "R3 popped");
    endtask

    // R4/R3: four levels, fifth rejected, levels unwind in order.
    task automatic t_nesting();
        push_blk(16'h0100, 16'h0120, 16'd0);
        push_blk(16'h0101, 16'h0119, 16'd1);
        push_blk(16'h0102, 16'h0118, 16'd1);
        push_blk(16'h0103, 16'h0103, 16'd1);
        check(!nest_overflow, "R4 fourth accepted", nest_overflow, 0);
        push_blk(16'h0200, 16'h0200, 16'd5);
        check(nest_overflow, "R4 overflow pulse", nest_overflow, 1);
        next_cycle();
        check(!nest_overflow, "R4 pulse one cycle", nest_overflow, 0);
        fetch_chk(16'h0200, 1'b0, '0, 1'b0, "R4 rejected level absent");
        fetch_chk(16'h0103, 1'b1, 16'h0103, 1'b0, "R4 level4 kept");
        fetch_chk(16'h0103, 1'b0, '0, 1'b0, "R3 level4 exit");
        fetch_chk(16'h0118, 1'b1, 16'h0102, 1'b0, "R3 level3 active");
        fetch_chk(16'h0118, 1'b0, '0, 1'b0, "R3 level3 exit");
        fetch_chk(16'h0119, 1'b1, 16'h0101, 1'b0, "R3 level2 active");
        fetch_chk(16'h0119, 1'b0, '0, 1'b0, "R3 level2 exit");
        fetch_chk(16'h0120, 1'b0, '0, 1'b0, "R3 level1 exit");
    endtask

    // R3: inner and outer share a last address.
    task automatic t_shared_end();
        push_blk(16'h0030, 16'h0040, 16'd1);
        push_blk(16'h0035, 16'h0040, 16'd0);
        fetch_chk(16'h0040, 1'b0, '0, 1'b0, "R3 inner retires");
        fetch_chk(16'h0040, 1'b1, 16'h0030, 1'b0, "R3 outer next fetch");
        fetch_chk(16'h0040, 1'b0, '0, 1'b0, "R3 outer retires");
    endtask

    // R5: count 2 gives two holds then a final issue; then disarmed.
    task automatic t_repeat();
        arm_rep(16'h0050, 16'd2);
        fetch_chk(16'h0050, 1'b0, '0, 1'b1, "R5 hold 1");
        fetch_chk(16'h0050, 1'b0, '0, 1'b1, "R5 hold 2");
        fetch_chk(16'h0050, 1'b0, '0, 1'b0, "R5 final issue");
        fetch_chk(16'h0050, 1'b0, '0, 1'b0, "R5 disarmed");
    endtask

    // R6: repeat on the block's last address.
    task automatic t_rep_in_block();
        push_blk(16'h0060, 16'h0062, 16'd1);
        arm_rep(16'h0062, 16'd1);
        fetch_chk(16'h0060, 1'b0, '0, 1'b0, "R6 body");
        fetch_chk(16'h0061, 1'b0, '0, 1'b0, "R6 body");
        fetch_chk(16'h0062, 1'b0, '0, 1'b1, "R6 hold masks block end");
        fetch_chk(16'h0062, 1'b1, 16'h0060, 1'b0, "R6 final issue loops");
        fetch_chk(16'h0060, 1'b0, '0, 1'b0, "R6 body");
        fetch_chk(16'h0061, 1'b0, '0, 1'b0, "R6 body");
        fetch_chk(16'h0062, 1'b0, '0, 1'b0, "R6 block exit");
    endtask

    // R7/R8: freeze a block loop and a repeat across an interrupt.
    task automatic t_interrupt();
        push_blk(16'h0070, 16'h0071, 16'd1);
        fetch_chk(16'h0070, 1'b0, '0, 1'b0, "R7 body");
        irq_enter = 1'b1;
        fetch_chk(16'h0071, 1'b0, '0, 1'b0, "R7 entry fetch abandoned");
        irq_enter = 1'b0;
        fetch_chk(16'h0071, 1'b0, '0, 1'b0, "R7 frozen");
        push_blk(16'h0090, 16'h0090, 16'd3);
        arm_rep(16'h0091, 16'd3);
        irq_return = 1'b1;
        fetch_chk(16'h0300, 1'b0, '0, 1'b0, "R7 return cycle");
        irq_return = 1'b0;
        fetch_chk(16'h0071, 1'b1, 16'h0070, 1'b0, "R7 resumes");
        fetch_chk(16'h0070, 1'b0, '0, 1'b0, "R7 body");
        fetch_chk(16'h0071, 1'b0, '0, 1'b0, "R7 count kept");
        fetch_chk(16'h0090, 1'b0, '0, 1'b0, "R8 frozen block ignored");
        fetch_chk(16'h0091, 1'b0, '0, 1'b0, "R8 frozen repeat ignored");
        arm_rep(16'h0080, 16'd2);
        fetch_chk(16'h0080, 1'b0, '0, 1'b1, "R7 rep hold 1");
        irq_enter = 1'b1;
        fetch_chk(16'h0080, 1'b0, '0, 1'b0, "R7 rep frozen");
        irq_enter = 1'b0;
        irq_return = 1'b1;
        fetch_chk(16'h0400, 1'b0, '0, 1'b0, "R7 isr");
        irq_return = 1'b0;
        fetch_chk(16'h0080, 1'b0, '0, 1'b1, "R7 rep refetch holds");
        fetch_chk(16'h0080, 1'b0, '0, 1'b0, "R7 rep final");
    endtask

    // R9: full count gives 65,536 passes of a one-word block.
    task automatic t_max_count();
        int ovr = 0;
        push_blk(16'h0500, 16'h0500, 16'hFFFF);
        fetch_valid = 1'b1;
        fetch_pc    = 16'h0500;
        for (int k = 0; k < 65536; k++) begin
            #1;
            if (pc_override) ovr++;
            next_cycle();
        end
        fetch_valid = 1'b0;
        check(ovr == 65535, "R9 loop backs", ovr, 65535);
        fetch_chk(16'h0500, 1'b0, '0, 1'b0, "R9 level retired");
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #1_500_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single_block();
        t_nesting();
        t_shared_end();
        t_repeat();
        t_rep_in_block();
        t_interrupt();
        t_max_count();
        summary();
    end

endmodule